// File: doc/BRIEF.md
# Planar Write Datapath with Read Latch

This block sits between a CPU byte port and a display memory organised as several parallel bit planes (four planes of eight bits by default). On every CPU read of display memory it captures the full word returned by all planes into an internal latch. On every CPU write it combines the CPU byte, the latch and a set of configuration fields into one word of per-plane write data, and passes the map mask through as the per-plane write enable.

Four write modes are offered: an arithmetic mode that rotates the CPU byte, optionally substitutes a per-plane set/reset colour and applies a logic function against the latch; a copy mode that writes the latch back unchanged; a splat mode that spreads one CPU bit across each plane; and a fill mode that uses the rotated CPU byte, qualified by the bit mask, to choose per pixel between the set/reset colour and the latch. In the two modes that apply the logic function, the bit mask picks which pixel bits take new data; the others are rewritten from the latch.

The write result is registered: it appears one cycle after the write strobe with a one-cycle `out_valid` pulse. No back-pressure exists; the memory is expected to accept every pulse, so the stream has a valid only and no ready. Plane p occupies bits [8p+7:8p] of every 32-bit word.

Top module: `gfxw_datapath`

## Requirements
- R1: While `rst_n` is low and after it rises, `out_valid` and `out_plane_en` are 0 and the latch holds all zeros until the first read.
- R2: A cycle with `rd_en` high loads `rd_planes` into the latch at that clock edge.
- R3: A cycle with `wr_en` high produces `out_valid` high in the next cycle only, with `out_plane_en` equal to `map_mask` of the write cycle.
- R4: In write mode 0 (`wr_mode`=0) the CPU byte is rotated right by `rot_cnt` (result bit i = CPU bit (i+rot_cnt) mod 8) before use.
- R5: In write mode 0, a plane p with `sr_enable[p]`=1 uses eight copies of `sr_color[p]` instead of the rotated CPU byte.
- R6: In write modes 0 and 2 the logic function `logic_fn` combines the data with the latch: 0 pass, 1 AND, 2 OR, 3 XOR.
- R7: In write mode 1 the output equals the latch, independent of CPU byte, bit mask, rotation and logic function.
- R8: In write mode 2 plane p's data is eight copies of CPU bit p, before the logic function.
- R9: In write mode 3 the rotated CPU byte ANDed with `bit_mask` selects per bit: 1 takes `sr_color[p]`, 0 takes the latch bit.
- R10: In write modes 0 and 2, bit positions where `bit_mask` is 0 take the latch bit of the same plane.
- R11: When `rd_en` and `wr_en` are high in the same cycle, the write uses the latch value from before that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | CPU display-memory read strobe, loads latch |
| rd_planes | input | 32 | Data read from all planes at the addressed location |
| wr_en | input | 1 | CPU display-memory write strobe |
| wr_byte | input | 8 | CPU write data byte |
| wr_mode | input | 2 | Write mode 0..3 |
| rot_cnt | input | 3 | Rotate-right count |
| logic_fn | input | 2 | Logic function 0 pass, 1 AND, 2 OR, 3 XOR |
| sr_color | input | 4 | Set/reset colour, one bit per plane |
| sr_enable | input | 4 | Set/reset substitution enable per plane (mode 0) |
| bit_mask | input | 8 | Per-pixel-bit write enable |
| map_mask | input | 4 | Per-plane write enable |
| out_valid | output | 1 | One-cycle pulse per write |
| out_data | output | 32 | Per-plane write data |
| out_plane_en | output | 4 | Per-plane write enable for this word |

## Verification
A corrupted latch is invisible on its own and only shows at the ports on the next write in modes 0 to 3, one cycle after that write strobe, so the bench follows every read with writes in mixed modes and copy mode in particular exposes the latch bit for bit. A wrong mode or function decode shows directly in `out_data` of the same write, one cycle after the strobe; a wrong rotation or mask bit shows as a single flipped pixel bit in one or all planes. The read/write collision case shows stale-versus-fresh latch use in the write issued with the read.

// File: rtl/gfxw_pkg.sv
package gfxw_pkg;
  typedef enum logic [1:0] {
    WM_ALU   = 2'd0,
    WM_COPY  = 2'd1,
    WM_SPLAT = 2'd2,
    WM_FILL  = 2'd3
  } wmode_e;

  typedef enum logic [1:0] {
    FN_PASS = 2'd0,
    FN_AND  = 2'd1,
    FN_OR   = 2'd2,
    FN_XOR  = 2'd3
  } lfn_e;
endpackage

// File: rtl/gfxw_rotr.sv
module gfxw_rotr #(
  parameter int W  = 8,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [2*W-1:0] dbl;
  always_comb begin
    dbl  = {din, din} >> amt;
    dout = dbl[W-1:0];
  end
endmodule

// File: rtl/gfxw_latch.sv
module gfxw_latch #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] din,
  output logic [N-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/gfxw_lane.sv
module gfxw_lane
  import gfxw_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] cpu_rot,
  input  logic         cpu_bit,
  input  logic         sr_en,
  input  logic         sr_bit,
  input  wmode_e       mode,
  input  lfn_e         fn,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] latch,
  output logic [W-1:0] dout
);
  logic [W-1:0] src, fres, masked, fsel;

  always_comb begin
    if (mode == WM_SPLAT) src = {W{cpu_bit}};
    else if (sr_en)       src = {W{sr_bit}};
    else                  src = cpu_rot;

    unique case (fn)
      FN_PASS: fres = src;
      FN_AND:  fres = src & latch;
      FN_OR:   fres = src | latch;
      default: fres = src ^ latch;
    endcase

    masked = (fres & mask) | (latch & ~mask);
    fsel   = cpu_rot & mask;

    unique case (mode)
      WM_COPY: dout = latch;
      WM_FILL: dout = (fsel & {W{sr_bit}}) | (~fsel & latch);
      default: dout = masked;
    endcase
  end
endmodule

// File: rtl/gfxw_datapath.sv
module gfxw_datapath
  import gfxw_pkg::*;
#(
  parameter int PW     = 8,
  parameter int PLANES = 4,
  localparam int RW    = $clog2(PW),
  localparam int DW    = PW * PLANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [DW-1:0]     rd_planes,
  input  logic              wr_en,
  input  logic [PW-1:0]     wr_byte,
  input  logic [1:0]        wr_mode,
  input  logic [RW-1:0]     rot_cnt,
  input  logic [1:0]        logic_fn,
  input  logic [PLANES-1:0] sr_color,
  input  logic [PLANES-1:0] sr_enable,
  input  logic [PW-1:0]     bit_mask,
  input  logic [PLANES-1:0] map_mask,
  output logic              out_valid,
  output logic [DW-1:0]     out_data,
  output logic [PLANES-1:0] out_plane_en
);
  logic [DW-1:0] latch_q;
  logic [PW-1:0] cpu_rot;
  logic [DW-1:0] word_c;

  gfxw_latch #(.N(DW)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(rd_en), .din(rd_planes), .q(latch_q)
  );

  gfxw_rotr #(.W(PW)) u_rot (
    .din(wr_byte), .amt(rot_cnt), .dout(cpu_rot)
  );

  for (genvar p = 0; p < PLANES; p++) begin : g_lane
    gfxw_lane #(.W(PW)) u_lane (
      .cpu_rot(cpu_rot),
      .cpu_bit(wr_byte[p]),
      .sr_en  (sr_enable[p]),
      .sr_bit (sr_color[p]),
      .mode   (wmode_e'(wr_mode)),
      .fn     (lfn_e'(logic_fn)),
      .mask   (bit_mask),
      .latch  (latch_q[p*PW +: PW]),
      .dout   (word_c[p*PW +: PW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_plane_en <= '0;
    end else begin
      out_valid <= wr_en;
      if (wr_en) begin
        out_data     <= word_c;
        out_plane_en <= map_mask;
      end
    end
  end
endmodule

// File: rtl/gfxw_checker.sv
module gfxw_checker #(
  parameter int PW     = 8,
  parameter int PLANES = 4,
  localparam int DW    = PW * PLANES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [DW-1:0]     rd_planes,
  input logic              wr_en,
  input logic [1:0]        wr_mode,
  input logic [PW-1:0]     bit_mask,
  input logic [PLANES-1:0] map_mask,
  input logic [DW-1:0]     latch_q,
  input logic              out_valid,
  input logic [DW-1:0]     out_data,
  input logic [PLANES-1:0] out_plane_en
);
  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(wr_en));

  assert_plane_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_plane_en == $past(map_mask)));

  assert_latch_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en) |-> (latch_q == $past(rd_planes)));

  assert_copy_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(wr_mode) == 2'd1)) |-> (out_data == $past(latch_q)));

  assert_mask_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(wr_mode[0]) && ($past(bit_mask) == '0))
      |-> (out_data == $past(latch_q)));
endmodule

bind gfxw_datapath gfxw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_planes(rd_planes),
  .wr_en(wr_en), .wr_mode(wr_mode), .bit_mask(bit_mask), .map_mask(map_mask),
  .latch_q(latch_q), .out_valid(out_valid), .out_data(out_data),
  .out_plane_en(out_plane_en)
);

// File: tb/sim_gfxw_datapath.sv
`timescale 1ns/1ps
module sim_gfxw_datapath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_planes = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_byte = '0;
  logic [1:0]  wr_mode = '0;
  logic [2:0]  rot_cnt = '0;
  logic [1:0]  logic_fn = '0;
  logic [3:0]  sr_color = '0;
  logic [3:0]  sr_enable = '0;
  logic [7:0]  bit_mask = '0;
  logic [3:0]  map_mask = '0;
  logic        out_valid;
  logic [31:0] out_data;
  logic [3:0]  out_plane_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] mlatch = '0;

  always #2.5 clk = ~clk;

  gfxw_datapath u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_planes(rd_planes),
    .wr_en(wr_en), .wr_byte(wr_byte), .wr_mode(wr_mode), .rot_cnt(rot_cnt),
    .logic_fn(logic_fn), .sr_color(sr_color), .sr_enable(sr_enable),
    .bit_mask(bit_mask), .map_mask(map_mask), .out_valid(out_valid),
    .out_data(out_data), .out_plane_en(out_plane_en)
  );

  function automatic logic [31:0] ref_word(logic [1:0] m, logic [1:0] f,
      logic [2:0] r, logic [3:0] sc, logic [3:0] se, logic [7:0] bm,
      logic [7:0] cb, logic [31:0] lt);
    logic [7:0] rb, d, a, l, s;
    logic [31:0] res;
    for (int i = 0; i < 8; i++) rb[i] = cb[(i + r) % 8];
    for (int p = 0; p < 4; p++) begin
      l = lt[p*8 +: 8];
      if (m == 2'd2) d = cb[p] ? 8'hFF : 8'h00;
      else if (se[p]) d = sc[p] ? 8'hFF : 8'h00;
      else d = rb;
      case (f)
        2'd0: a = d;
        2'd1: a = d & l;
        2'd2: a = d | l;
        default: a = d ^ l;
      endcase
      s = rb & bm;
      case (m)
        2'd1: res[p*8 +: 8] = l;
        2'd3: res[p*8 +: 8] = (s & (sc[p] ? 8'hFF : 8'h00)) | (~s & l);
        default: res[p*8 +: 8] = (a & bm) | (l & ~bm);
      endcase
    end
    return res;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic do_rd(logic [31:0] p);
    rd_en = 1'b1; rd_planes = p;
    @(negedge clk);
    rd_en = 1'b0;
    mlatch = p;
  endtask

  task automatic do_wr(string tag);
    logic [31:0] exp;
    logic [3:0] mm;
    exp = ref_word(wr_mode, logic_fn, rot_cnt, sr_color, sr_enable, bit_mask, wr_byte, mlatch);
    mm = map_mask;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk({tag, " valid R3"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " plane_en R3"}, {28'd0, out_plane_en}, {28'd0, mm});
    chk(tag, out_data, exp);
    @(negedge clk);
    chk("R3 valid drop", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic cfg(logic [1:0] m, logic [1:0] f, logic [2:0] r,
      logic [3:0] sc, logic [3:0] se, logic [7:0] bm, logic [7:0] cb, logic [3:0] mm);
    wr_mode = m; logic_fn = f; rot_cnt = r; sr_color = sc; sr_enable = se;
    bit_mask = bm; wr_byte = cb; map_mask = mm;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] dummy;
    dummy = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R1 reset plane_en", {28'd0, out_plane_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle valid", {31'd0, out_valid}, 32'd0);
    // R1: latch zero after reset, seen through copy mode
    cfg(2'd1, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 8'hA5, 4'hF);
    do_wr("R1 latch zero");

    // R2 + R7: read then copy, copy ignores mask, rotation, function
    do_rd(32'h1234_ABCD);
    cfg(2'd1, 2'd3, 3'd5, 4'hF, 4'hF, 8'h0F, 8'hFF, 4'h5);
    do_wr("R2 R7 copy latch");

    // R4: rotate corners
    do_rd(32'h0000_0000);
    cfg(2'd0, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 8'h81, 4'hF);
    do_wr("R4 rot0");
    cfg(2'd0, 2'd0, 3'd7, 4'h0, 4'h0, 8'hFF, 8'h81, 4'hF);
    do_wr("R4 rot7");
    cfg(2'd0, 2'd0, 3'd1, 4'h0, 4'h0, 8'hFF, 8'h01, 4'h3);
    do_wr("R4 rot1 wrap");

    // R5: set/reset substitution on some planes
    cfg(2'd0, 2'd0, 3'd2, 4'b1010, 4'b0110, 8'hFF, 8'h3C, 4'hF);
    do_wr("R5 set reset");

    // R6: each logic function in mode 0 and mode 2
    do_rd(32'hF0CC_AA0F);
    for (int f = 0; f < 4; f++) begin
      cfg(2'd0, f[1:0], 3'd0, 4'h0, 4'h0, 8'hFF, 8'h5A, 4'hF);
      do_wr("R6 mode0 fn");
      cfg(2'd2, f[1:0], 3'd0, 4'h0, 4'h0, 8'hFF, 8'h09, 4'hF);
      do_wr("R6 R8 mode2 fn");
    end

    // R10: mask off in modes 0 and 2 keeps latch
    cfg(2'd0, 2'd3, 3'd3, 4'h0, 4'h0, 8'h00, 8'hFF, 4'hF);
    do_wr("R10 mask zero mode0");
    cfg(2'd2, 2'd0, 3'd0, 4'h0, 4'h0, 8'h81, 8'h0F, 4'hF);
    do_wr("R10 partial mask mode2");

    // R9: fill mode, including zero mask and full select
    cfg(2'd3, 2'd2, 3'd4, 4'b1001, 4'h0, 8'hF0, 8'h3C, 4'hF);
    do_wr("R9 fill");
    cfg(2'd3, 2'd0, 3'd0, 4'hF, 4'h0, 8'h00, 8'hFF, 4'hF);
    do_wr("R9 fill mask zero");

    // R11: read and write in same cycle uses old latch
    cfg(2'd1, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 8'h00, 4'hF);
    begin
      logic [31:0] old;
      old = mlatch;
      rd_en = 1'b1; rd_planes = 32'hDEAD_BEEF; wr_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
      chk("R11 collision old latch", out_data, old);
      mlatch = 32'hDEAD_BEEF;
      cfg(2'd1, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 8'h00, 4'hF);
      do_wr("R11 R2 new latch");
    end

    // random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 2) == 0) do_rd($urandom);
      cfg($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 7),
          $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 255),
          $urandom_range(0, 255), $urandom_range(0, 15));
      case (wr_mode)
        2'd0: do_wr("R4 R5 R6 R10 rand mode0");
        2'd1: do_wr("R7 rand mode1");
        2'd2: do_wr("R8 R6 R10 rand mode2");
        default: do_wr("R9 rand mode3");
      endcase
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule